// File: doc/BRIEF.md
# Memory Error Reporting Register File

This block is an APB slave register file that sits beside an SRAM and its error checker. The checker sends single-cycle pulses, one for a correctable error and one for an uncorrectable error. For each error class the block keeps a sticky flag, a mask bit, a saturating event counter, a status word and a clear control. An interrupt line is raised while any unmasked flag is set. The block also drives a configuration field and a request that asks the memory to initialise itself after reset.

Whether that initialisation runs is decided by the reset value of a skip bit in the init control register. The default build clears the bit at reset, so the block raises the init request one cycle after reset and holds it until the memory returns an init-done pulse. The no-init build (`NO_INIT=1`) sets the bit at reset and never raises the request. A parity build (`PARITY=1`) keeps a single error class on the correctable input. In that build the second class's address range is unmapped and the uncorrectable input is ignored.

Access uses a 6-bit byte address and 32-bit data, with no wait states. Fixed registers sit at 0x00 init control (bit 0 skip), 0x04 init status, 0x08 memory config and 0x0C spare. Class `c` (0 = correctable, 1 = uncorrectable) occupies 20 bytes starting at 0x10 + 20·c, at these offsets from its base:

| Offset | Register | Access |
|--------|----------|--------|
| +0x00 | flag, bit 0 | read only |
| +0x04 | mask, bit 0 | read/write |
| +0x08 | count | read only |
| +0x0C | status | read only |
| +0x10 | clear | write only, reads 0 |

Top module: `memErrRegs`

## Requirements
- R1: The memory config register at 0x08 (low `MEM_CFG_W` bits, reset 0) and the 32-bit spare at 0x0C (reset 0) read back what was written, and the config value drives `memCfg`. Every access completes in one access cycle (`apbReady` is 1).
- R2: An access to an unmapped or misaligned offset (0x38–0x3F, any address with bits [1:0] ≠ 0) returns 0 and sets `apbSlvErr`. A write to a read-only register (flag, count, status, init status) changes nothing and sets no error.
- R3: An event pulse sets its class's flag (bit 0 of the flag register). The flag stays set until that class is cleared. An event of one class leaves the other class untouched.
- R4: The count register of a class goes up by one for each cycle its event input is high. It stops at 2^`CNT_W`−1 and never wraps.
- R5: Writing 1 to bit 0 of a class's clear register zeroes that class's flag and count. If an event of that class arrives in the same cycle, the result is flag 1 and count 1. Writing the clear register with bit 0 = 0 does nothing.
- R6: `irq` is high exactly when some class has its flag set and its mask bit (reset 0) clear.
- R7: The status word of a class reads bit 0 = flag AND NOT mask and bit 1 = count saturated.
- R8: With skip bit reset value 0, `memInitReq` rises one cycle after reset and falls after the cycle in which `memInitDone` is high. Init status reads 0x1 (busy) before that and 0x2 (done) after it. Later `memInitDone` pulses are ignored.
- R9: With `NO_INIT=1` the skip bit reads 1 after reset, `memInitReq` never asserts and init status reads 0.
- R10: With `PARITY=1` only class 0 exists. Offsets 0x24–0x37 respond as unmapped, and `uncorrErr` has no effect on `irq` or on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| apbSel | input | 1 | APB select |
| apbEnable | input | 1 | APB enable (access phase) |
| apbWrite | input | 1 | APB write when 1, read when 0 |
| apbAddr | input | ADDR_W | APB byte address |
| apbWdata | input | DATA_W | APB write data |
| apbRdata | output | DATA_W | APB read data |
| apbReady | output | 1 | APB ready, always 1 |
| apbSlvErr | output | 1 | APB error for unmapped or misaligned access |
| corrErr | input | 1 | Correctable error pulse |
| uncorrErr | input | 1 | Uncorrectable error pulse |
| memInitDone | input | 1 | Memory initialisation finished pulse |
| irq | output | 1 | Interrupt, any unmasked flag set |
| memInitReq | output | 1 | Request to initialise the memory |
| memCfg | output | MEM_CFG_W | Memory configuration field |

## Verification
The hardest situations to reach from the ports are a clear landing in the same cycle as a fresh event, and a counter held at saturation. The bench reaches the first by raising `corrErr` during the access phase of the clear write. It reaches the second with a long back-to-back run of `uncorrErr` pulses into a narrow counter. A default build and a parity build with no-init share one bus, so each write also shows how the second class is unmapped and how the uncorrectable input is ignored in the parity build. A behavioural model of both builds is compared with every output on every clock.

// File: rtl/memErrPkg.sv
package memErrPkg;
  localparam int MAX_CLASSES  = 2;
  localparam int CLASS_BASE   = 16;
  localparam int CLASS_STRIDE = 20;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_INIT_CTRL, SEL_INIT_STAT, SEL_MEM_CFG, SEL_SPARE,
    SEL_FLAG, SEL_MASK, SEL_COUNT, SEL_STATUS, SEL_CLEAR
  } regSelT;

  typedef enum logic [1:0] {INIT_ARM, INIT_BUSY, INIT_DONE, INIT_OFF} initStateT;

  typedef struct packed {
    logic                   initCtrlWr;
    logic                   memCfgWr;
    logic                   spareWr;
    logic [MAX_CLASSES-1:0] maskWr;
    logic [MAX_CLASSES-1:0] clearWr;
    regSelT                 rdSel;
    logic                   rdClass;
    logic                   initBusyFlag;
    logic                   initDoneFlag;
  } ctrlStrobeT;
endpackage

// File: rtl/memErrCounter.sv
module memErrCounter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             event_i,
  input  logic             clear,
  output logic             flag,
  output logic [CNT_W-1:0] count,
  output logic             saturated
);
  logic             flagQ;
  logic [CNT_W-1:0] countQ;

  assign saturated = &countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= 1'b0;
      countQ <= '0;
    end else if (clear) begin
      // a same-cycle event survives the clear as the first new event
      flagQ  <= event_i;
      countQ <= event_i ? CNT_W'(1) : '0;
    end else if (event_i) begin
      flagQ <= 1'b1;
      if (!saturated) countQ <= countQ + CNT_W'(1);
    end
  end

  assign flag  = flagQ;
  assign count = countQ;
endmodule

// File: rtl/memErrCtrl.sv
module memErrCtrl
  import memErrPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int NUM_CLASSES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              apbSel,
  input  logic              apbEnable,
  input  logic              apbWrite,
  input  logic [ADDR_W-1:0] apbAddr,
  input  logic              skipInit,
  input  logic              memInitDone,
  output ctrlStrobeT        strobe,
  output logic              apbSlvErr,
  output logic              memInitReq
);
  regSelT    sel;
  logic      cls;
  logic      access;
  logic      wrHit;
  initStateT initState;

  always_comb begin
    logic [ADDR_W-1:0] rel;
    sel = SEL_NONE;
    cls = 1'b0;
    rel = '0;
    if (apbAddr[1:0] == 2'b00) begin
      if (apbAddr < ADDR_W'(CLASS_BASE)) begin
        case (apbAddr[3:2])
          2'd0:    sel = SEL_INIT_CTRL;
          2'd1:    sel = SEL_INIT_STAT;
          2'd2:    sel = SEL_MEM_CFG;
          default: sel = SEL_SPARE;
        endcase
      end else begin
        for (int c = 0; c < NUM_CLASSES; c++) begin
          rel = apbAddr - ADDR_W'(CLASS_BASE + c * CLASS_STRIDE);
          if (apbAddr >= ADDR_W'(CLASS_BASE + c * CLASS_STRIDE) &&
              rel < ADDR_W'(CLASS_STRIDE)) begin
            cls = 1'(c);
            case (rel[4:2])
              3'd0:    sel = SEL_FLAG;
              3'd1:    sel = SEL_MASK;
              3'd2:    sel = SEL_COUNT;
              3'd3:    sel = SEL_STATUS;
              default: sel = SEL_CLEAR;
            endcase
          end
        end
      end
    end
  end

  assign access    = apbSel & apbEnable;
  assign apbSlvErr = access & (sel == SEL_NONE);
  assign wrHit     = access & apbWrite & (sel != SEL_NONE);

  always_comb begin
    strobe            = '0;
    strobe.rdSel      = sel;
    strobe.rdClass    = cls;
    strobe.initCtrlWr = wrHit && sel == SEL_INIT_CTRL;
    strobe.memCfgWr   = wrHit && sel == SEL_MEM_CFG;
    strobe.spareWr    = wrHit && sel == SEL_SPARE;
    for (int c = 0; c < MAX_CLASSES; c++) begin
      strobe.maskWr[c]  = wrHit && sel == SEL_MASK  && cls == 1'(c);
      strobe.clearWr[c] = wrHit && sel == SEL_CLEAR && cls == 1'(c);
    end
    strobe.initBusyFlag = initState == INIT_BUSY;
    strobe.initDoneFlag = initState == INIT_DONE;
  end

  // init sequencing: the cycle after reset reads the skip bit's reset value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initState <= INIT_ARM;
    else begin
      case (initState)
        INIT_ARM:  initState <= skipInit ? INIT_OFF : INIT_BUSY;
        INIT_BUSY: if (memInitDone) initState <= INIT_DONE;
        default:   initState <= initState;
      endcase
    end
  end

  assign memInitReq = initState == INIT_BUSY;
endmodule

// File: rtl/memErrDatapath.sv
module memErrDatapath
  import memErrPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16,
  parameter int MEM_CFG_W   = 8,
  parameter int NUM_CLASSES = 2,
  parameter bit NO_INIT     = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobeT             strobe,
  input  logic [DATA_W-1:0]      apbWdata,
  input  logic [MAX_CLASSES-1:0] evt,
  output logic [DATA_W-1:0]      apbRdata,
  output logic                   irq,
  output logic [MEM_CFG_W-1:0]   memCfg,
  output logic                   skipInit
);
  logic                   skipQ;
  logic [MEM_CFG_W-1:0]   memCfgQ;
  logic [DATA_W-1:0]      spareQ;
  logic [MAX_CLASSES-1:0] maskQ;
  logic [MAX_CLASSES-1:0] classFlag;
  logic [MAX_CLASSES-1:0] classSat;
  logic [CNT_W-1:0]       classCount [MAX_CLASSES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skipQ   <= NO_INIT;
      memCfgQ <= '0;
      spareQ  <= '0;
      maskQ   <= '0;
    end else begin
      if (strobe.initCtrlWr) skipQ   <= apbWdata[0];
      if (strobe.memCfgWr)   memCfgQ <= apbWdata[MEM_CFG_W-1:0];
      if (strobe.spareWr)    spareQ  <= apbWdata;
      for (int c = 0; c < MAX_CLASSES; c++)
        if (strobe.maskWr[c]) maskQ[c] <= apbWdata[0];
    end
  end

  for (genvar c = 0; c < MAX_CLASSES; c++) begin : gClass
    if (c < NUM_CLASSES) begin : gLive
      memErrCounter #(.CNT_W(CNT_W)) uCounter (
        .clk       (clk),
        .rstN      (rstN),
        .event_i   (evt[c]),
        .clear     (strobe.clearWr[c] & apbWdata[0]),
        .flag      (classFlag[c]),
        .count     (classCount[c]),
        .saturated (classSat[c])
      );
    end else begin : gAbsent
      assign classFlag[c]  = 1'b0;
      assign classCount[c] = '0;
      assign classSat[c]   = 1'b0;
    end
  end

  always_comb begin
    apbRdata = '0;
    case (strobe.rdSel)
      SEL_INIT_CTRL: apbRdata[0]   = skipQ;
      SEL_INIT_STAT: apbRdata[1:0] = {strobe.initDoneFlag, strobe.initBusyFlag};
      SEL_MEM_CFG:   apbRdata[MEM_CFG_W-1:0] = memCfgQ;
      SEL_SPARE:     apbRdata = spareQ;
      SEL_FLAG:      apbRdata[0] = classFlag[strobe.rdClass];
      SEL_MASK:      apbRdata[0] = maskQ[strobe.rdClass];
      SEL_COUNT:     apbRdata[CNT_W-1:0] = classCount[strobe.rdClass];
      SEL_STATUS:    apbRdata[1:0] = {classSat[strobe.rdClass],
                                      classFlag[strobe.rdClass] & ~maskQ[strobe.rdClass]};
      default:       apbRdata = '0;
    endcase
  end

  assign irq      = |(classFlag & ~maskQ);
  assign memCfg   = memCfgQ;
  assign skipInit = skipQ;
endmodule

// File: rtl/memErrRegs.sv
module memErrRegs
  import memErrPkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int MEM_CFG_W = 8,
  parameter bit PARITY    = 1'b0,
  parameter bit NO_INIT   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 apbSel,
  input  logic                 apbEnable,
  input  logic                 apbWrite,
  input  logic [ADDR_W-1:0]    apbAddr,
  input  logic [DATA_W-1:0]    apbWdata,
  output logic [DATA_W-1:0]    apbRdata,
  output logic                 apbReady,
  output logic                 apbSlvErr,
  input  logic                 corrErr,
  input  logic                 uncorrErr,
  input  logic                 memInitDone,
  output logic                 irq,
  output logic                 memInitReq,
  output logic [MEM_CFG_W-1:0] memCfg
);
  localparam int NUM_CLASSES = PARITY ? 1 : 2;

  ctrlStrobeT strobe;
  logic       skipInit;

  memErrCtrl #(.ADDR_W(ADDR_W), .NUM_CLASSES(NUM_CLASSES)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .apbSel      (apbSel),
    .apbEnable   (apbEnable),
    .apbWrite    (apbWrite),
    .apbAddr     (apbAddr),
    .skipInit    (skipInit),
    .memInitDone (memInitDone),
    .strobe      (strobe),
    .apbSlvErr   (apbSlvErr),
    .memInitReq  (memInitReq)
  );

  memErrDatapath #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .MEM_CFG_W(MEM_CFG_W),
    .NUM_CLASSES(NUM_CLASSES), .NO_INIT(NO_INIT)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .apbWdata (apbWdata),
    .evt      ({uncorrErr, corrErr}),
    .apbRdata (apbRdata),
    .irq      (irq),
    .memCfg   (memCfg),
    .skipInit (skipInit)
  );

  assign apbReady = 1'b1;
endmodule

// File: rtl/memErrChecker.sv
module memErrChecker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              apbSel,
  input logic              apbEnable,
  input logic              apbWrite,
  input logic [DATA_W-1:0] apbRdata,
  input logic              apbSlvErr,
  input logic              corrErr,
  input logic              uncorrErr,
  input logic              memInitDone,
  input logic              irq,
  input logic              memInitReq
);
  logic firstCycle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) firstCycle <= 1'b1;
    else       firstCycle <= 1'b0;
  end

  assert_err_reads_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (apbSel && apbEnable && !apbWrite && apbSlvErr) |-> apbRdata == '0);

  assert_err_only_in_access_R2: assert property (@(posedge clk) disable iff (!rstN)
    apbSlvErr |-> (apbSel && apbEnable));

  assert_irq_rise_has_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(corrErr || uncorrErr || (apbSel && apbEnable && apbWrite)));

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(apbSel && apbEnable && apbWrite));

  assert_init_once_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memInitReq) |-> $past(firstCycle));

  assert_init_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memInitReq && memInitDone) |=> !memInitReq);
endmodule

bind memErrRegs memErrChecker #(.DATA_W(DATA_W)) uChecker (
  .clk         (clk),
  .rstN        (rstN),
  .apbSel      (apbSel),
  .apbEnable   (apbEnable),
  .apbWrite    (apbWrite),
  .apbRdata    (apbRdata),
  .apbSlvErr   (apbSlvErr),
  .corrErr     (corrErr),
  .uncorrErr   (uncorrErr),
  .memInitDone (memInitDone),
  .irq         (irq),
  .memInitReq  (memInitReq)
);

// File: tb/tb_memErrRegs.sv
`timescale 1ns/1ps
module tb_memErrRegs;
  localparam int CMAX = 255;

  logic        clk = 1'b0;
  logic        rstN;
  logic        apbSel = 0, apbEnable = 0, apbWrite = 0;
  logic [5:0]  apbAddr = '0;
  logic [31:0] apbWdata = '0;
  logic        corrErr = 0, uncorrErr = 0, memInitDone = 0;
  logic [31:0] rdataA, rdataB;
  logic        readyA, readyB, errA, errB, irqA, irqB, reqA, reqB;
  logic [7:0]  cfgA, cfgB;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  memErrRegs #(.CNT_W(8)) dut (
    .clk(clk), .rstN(rstN), .apbSel(apbSel), .apbEnable(apbEnable), .apbWrite(apbWrite),
    .apbAddr(apbAddr), .apbWdata(apbWdata), .apbRdata(rdataA), .apbReady(readyA),
    .apbSlvErr(errA), .corrErr(corrErr), .uncorrErr(uncorrErr), .memInitDone(memInitDone),
    .irq(irqA), .memInitReq(reqA), .memCfg(cfgA));

  memErrRegs #(.CNT_W(8), .PARITY(1'b1), .NO_INIT(1'b1)) dutPar (
    .clk(clk), .rstN(rstN), .apbSel(apbSel), .apbEnable(apbEnable), .apbWrite(apbWrite),
    .apbAddr(apbAddr), .apbWdata(apbWdata), .apbRdata(rdataB), .apbReady(readyB),
    .apbSlvErr(errB), .corrErr(corrErr), .uncorrErr(uncorrErr), .memInitDone(memInitDone),
    .irq(irqB), .memInitReq(reqB), .memCfg(cfgB));

  // ---------------- reference model (index 0: default build, 1: parity/no-init)
  int flagM [2][2];
  int cntM  [2][2];
  int maskM [2][2];
  int skipM [2];
  int cfgM  [2];
  int stM   [2];   // 0 arm, 1 busy, 2 done, 3 off
  logic [31:0] spareM [2];
  int nclsM   [2] = '{2, 1};
  int noInitM [2] = '{0, 1};

  function automatic void modelReset();
    for (int m = 0; m < 2; m++) begin
      skipM[m] = noInitM[m]; cfgM[m] = 0; stM[m] = 0; spareM[m] = '0;
      for (int c = 0; c < 2; c++) begin flagM[m][c] = 0; cntM[m][c] = 0; maskM[m][c] = 0; end
    end
  endfunction

  // kind: 0 ctrl, 1 stat, 2 cfg, 3 spare, 4 flag, 5 mask, 6 count, 7 status, 8 clear
  function automatic void decodeM(int m, logic [5:0] a, output int kind, output int cls,
                                  output bit err);
    int rel;
    kind = 0; cls = 0; err = 0;
    if (a[1:0] != 0) begin err = 1; return; end
    if (a < 16) begin kind = a / 4; return; end
    rel = a - 16; cls = rel / 20;
    if (cls >= nclsM[m]) begin err = 1; return; end
    kind = 4 + (rel % 20) / 4;
  endfunction

  function automatic logic [31:0] expRead(int m, int kind, int cls);
    case (kind)
      0: return 32'(skipM[m]);
      1: return (stM[m] == 1) ? 32'h1 : (stM[m] == 2) ? 32'h2 : 32'h0;
      2: return 32'(cfgM[m]);
      3: return spareM[m];
      4: return 32'(flagM[m][cls]);
      5: return 32'(maskM[m][cls]);
      6: return 32'(cntM[m][cls]);
      7: return 32'(((cntM[m][cls] == CMAX) ? 2 : 0) + ((flagM[m][cls] != 0 && maskM[m][cls] == 0) ? 1 : 0));
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagFor(int m, int kind);
    case (kind)
      1: return (m == 0) ? "R8" : "R9";
      4: return "R3";
      5: return "R6";
      6: return "R4";
      7: return "R7";
      8: return "R5";
      default: return "R1";
    endcase
  endfunction

  initial modelReset();

  always @(posedge clk or negedge rstN) begin
    if (!rstN) modelReset();
    else begin
      for (int m = 0; m < 2; m++) begin
        int kind, cls; bit err, wr, ev, clr;
        if (stM[m] == 0) stM[m] = (skipM[m] != 0) ? 3 : 1;
        else if (stM[m] == 1 && memInitDone) stM[m] = 2;
        decodeM(m, apbAddr, kind, cls, err);
        wr = apbSel && apbEnable && apbWrite && !err;
        for (int c = 0; c < nclsM[m]; c++) begin
          ev  = (c == 0) ? corrErr : uncorrErr;
          clr = wr && kind == 8 && cls == c && apbWdata[0];
          if (clr) begin flagM[m][c] = ev; cntM[m][c] = ev; end
          else if (ev) begin
            flagM[m][c] = 1;
            if (cntM[m][c] < CMAX) cntM[m][c]++;
          end
        end
        if (wr) begin
          if (kind == 0) skipM[m] = apbWdata[0];
          if (kind == 2) cfgM[m]  = apbWdata[7:0];
          if (kind == 3) spareM[m] = apbWdata;
          if (kind == 5) maskM[m][cls] = apbWdata[0];
        end
      end
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // per-clock comparison, sampled 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    for (int m = 0; m < 2; m++) begin
      int kind, cls; bit err, irqE, irqV, reqV, errV;
      logic [31:0] rdV, expV; logic [7:0] cfgV;
      irqV = (m == 0) ? irqA : irqB;  reqV = (m == 0) ? reqA : reqB;
      errV = (m == 0) ? errA : errB;  rdV  = (m == 0) ? rdataA : rdataB;
      cfgV = (m == 0) ? cfgA : cfgB;
      irqE = 0;
      for (int c = 0; c < nclsM[m]; c++)
        if (flagM[m][c] != 0 && maskM[m][c] == 0) irqE = 1;
      check(irqV == irqE, (m == 0) ? "R6" : "R10", 32'(irqV), 32'(irqE));
      check(reqV == (stM[m] == 1), (m == 0) ? "R8" : "R9", 32'(reqV), 32'(stM[m] == 1));
      check(cfgV == 8'(cfgM[m]), "R1", 32'(cfgV), 32'(cfgM[m]));
      check(((m == 0) ? readyA : readyB) == 1'b1, "R1", 32'(readyA), 32'h1);
      if (apbSel && apbEnable) begin
        decodeM(m, apbAddr, kind, cls, err);
        check(errV == err, (m == 1 && apbAddr >= 6'h24 && apbAddr < 6'h38) ? "R10" : "R2",
              32'(errV), 32'(err));
        if (!apbWrite) begin
          expV = err ? 32'h0 : expRead(m, kind, cls);
          check(rdV == expV, err ? "R2" : tagFor(m, kind), rdV, expV);
        end
      end
    end
  end

  // ---------------- stimulus helpers
  task automatic apbXfer(input logic [5:0] a, input logic wr, input logic [31:0] d,
                         input bit withCorr, output logic [31:0] rA, output logic [31:0] rB,
                         output logic eA, output logic eB);
    @(negedge clk); apbSel = 1; apbEnable = 0; apbWrite = wr; apbAddr = a; apbWdata = d;
    @(negedge clk); apbEnable = 1; if (withCorr) corrErr = 1;
    #1; rA = rdataA; rB = rdataB; eA = errA; eB = errB;
    @(negedge clk); apbSel = 0; apbEnable = 0; apbWrite = 0; corrErr = 0;
  endtask

  task automatic apbWr(input logic [5:0] a, input logic [31:0] d);
    logic [31:0] x, y; logic p, q;
    apbXfer(a, 1'b1, d, 1'b0, x, y, p, q);
  endtask

  task automatic apbRd(input logic [5:0] a, output logic [31:0] rA, output logic [31:0] rB,
                       output logic eA, output logic eB);
    apbXfer(a, 1'b0, 32'h0, 1'b0, rA, rB, eA, eB);
  endtask

  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (which == 0) corrErr = 1; else if (which == 1) uncorrErr = 1; else memInitDone = 1;
    end
    @(negedge clk); corrErr = 0; uncorrErr = 0; memInitDone = 0;
  endtask

  // ---------------- directed sequence
  initial begin
    logic [31:0] a, b; logic ea, eb;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    check(irqA == 0 && reqA == 0 && rdataA == 0, "R8", {irqA, reqA}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(reqA == 1'b1, "R8", 32'(reqA), 32'h1);
    check(reqB == 1'b0, "R9", 32'(reqB), 32'h0);
    apbRd(6'h04, a, b, ea, eb);
    check(a == 32'h1, "R8", a, 32'h1);
    check(b == 32'h0, "R9", b, 32'h0);
    apbRd(6'h00, a, b, ea, eb);
    check(a == 32'h0, "R8", a, 32'h0);
    check(b == 32'h1, "R9", b, 32'h1);
    pulse(2, 1);
    apbRd(6'h04, a, b, ea, eb);
    check(a == 32'h2, "R8", a, 32'h2);
    check(b == 32'h0 && reqB == 0, "R9", b, 32'h0);

    apbWr(6'h08, 32'h1A5);
    apbRd(6'h08, a, b, ea, eb);
    check(a == 32'hA5 && cfgA == 8'hA5, "R1", a, 32'hA5);
    apbWr(6'h0C, 32'hDEAD0123);
    apbRd(6'h0C, a, b, ea, eb);
    check(a == 32'hDEAD0123, "R1", a, 32'hDEAD0123);

    apbWr(6'h10, 32'h1);
    apbRd(6'h10, a, b, ea, eb);
    check(a == 0 && irqA == 0, "R2", a, 32'h0);
    apbRd(6'h38, a, b, ea, eb);
    check(a == 0 && ea == 1, "R2", {a[30:0], ea}, 32'h1);
    apbRd(6'h02, a, b, ea, eb);
    check(ea == 1 && eb == 1, "R2", {ea, eb}, 32'h3);
    apbRd(6'h24, a, b, ea, eb);
    check(ea == 0, "R2", 32'(ea), 32'h0);
    check(eb == 1 && b == 0, "R10", 32'(eb), 32'h1);

    pulse(0, 3);
    apbRd(6'h18, a, b, ea, eb);
    check(a == 3, "R4", a, 32'h3);
    check(b == 3, "R10", b, 32'h3);
    apbRd(6'h2C, a, b, ea, eb);
    check(a == 0, "R3", a, 32'h0);
    check(irqA == 1, "R6", 32'(irqA), 32'h1);
    apbWr(6'h14, 32'h1);
    check(irqA == 0 && irqB == 0, "R6", {irqA, irqB}, 32'h0);
    apbRd(6'h1C, a, b, ea, eb);
    check(a == 0, "R7", a, 32'h0);

    pulse(1, 300);
    apbRd(6'h2C, a, b, ea, eb);
    check(a == CMAX, "R4", a, CMAX);
    apbRd(6'h30, a, b, ea, eb);
    check(a == 3, "R7", a, 32'h3);
    check(irqA == 1, "R6", 32'(irqA), 32'h1);
    check(irqB == 0, "R10", 32'(irqB), 32'h0);
    apbRd(6'h10, a, b, ea, eb);
    check(b == 1, "R10", b, 32'h1);

    apbWr(6'h34, 32'h0);
    apbRd(6'h2C, a, b, ea, eb);
    check(a == CMAX, "R5", a, CMAX);
    apbWr(6'h34, 32'h1);
    apbRd(6'h2C, a, b, ea, eb);
    check(a == 0, "R5", a, 32'h0);
    apbRd(6'h24, a, b, ea, eb);
    check(a == 0 && irqA == 0, "R5", a, 32'h0);

    apbXfer(6'h20, 1'b1, 32'h1, 1'b1, a, b, ea, eb);
    apbRd(6'h18, a, b, ea, eb);
    check(a == 1 && b == 1, "R5", a, 32'h1);
    apbRd(6'h10, a, b, ea, eb);
    check(a == 1, "R5", a, 32'h1);
    apbWr(6'h20, 32'h1);
    apbRd(6'h18, a, b, ea, eb);
    check(a == 0, "R5", a, 32'h0);

    pulse(2, 2);
    apbRd(6'h04, a, b, ea, eb);
    check(a == 32'h2 && reqA == 0, "R8", a, 32'h2);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule